// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after reset. It reads an optional serial EEPROM over a four-wire Microwire-style link, checks whether a device is fitted, and finds out how wide its address is. It then walks a zoned list of 16-bit records and turns each accepted record into one register write. These writes go out on a valid/ready stream, each carrying a zone flag, a 7-bit offset and an 8-bit value. The register file that consumes the stream is outside the block.

Two zones are supported. The unit-preload zone lets the internal serial channels and the parallel port be set up before any host driver runs. Its records are forwarded without filtering. The header zone overwrites bytes of the configuration header, and only offsets on a fixed list are accepted. If no EEPROM answers, or if word 0 reads as all ones, nothing is written and every register keeps its reset default.

Host configuration requests that arrive while loading is still in progress are answered with a retry. Once `load_done_o` rises, requests are no longer held off. The write stream follows the usual rules. A write is offered by raising valid, and its payload must not change until a cycle in which ready is also high. Only one write is ever outstanding, and the loader reads no further words while a write is stalled.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ee_cs_o`, `wr_valid_o` and `load_done_o` are all 0.
- R2: Every EEPROM transaction begins with a start bit of 1 followed by the read opcode bits 1,0, with the address sent MSB first. `ee_sk_o` is high only while `ee_cs_o` is high, and `ee_do_i` is sampled at the end of each high phase of `ee_sk_o`.
- R3: The address width is taken from the first address bit count, between MIN_AW (6) and MAX_AW (8), after which the device drives a 0 on `ee_do_i`. If no such 0 has appeared by MAX_AW bits, the EEPROM is treated as absent: no writes are issued and loading ends.
- R4: If word 0 reads as 16'hFFFF, the EEPROM is treated as absent and no writes are issued.
- R5: In word 0, bit 0 marks the unit-preload zone as present and bit 1 marks the header zone as present. The unit-preload records start at word 1. The header records start at word 1 when bit 0 is clear, and otherwise at the word after the last unit-preload record. When neither bit is set, no writes are issued.
- R6: In a record, bit 15 means another record follows in the same zone, bits 14:8 hold the offset and bits 7:0 hold the value. When bit 15 is 0, the zone ends.
- R7: Every unit-preload record produces one write with `wr_zone_o`=0, its offset and its value, in EEPROM order.
- R8: A header record produces a write with `wr_zone_o`=1 only if its offset is 0x2E, 0x2F, 0x3D, 0x42 or 0x43. Records with any other offset are skipped with no write.
- R9: Loading stops after the last word the EEPROM holds (2^width words), even when that word's continue bit is set.
- R10: While `wr_valid_o` is high and `wr_ready_i` is low, the next cycle keeps `wr_valid_o` high and the zone, offset and value unchanged.
- R11: `load_done_o` rises only after the last write has been accepted. It then stays high until reset, with no further writes and `ee_cs_o` low.
- R12: `cfg_retry_o` equals `cfg_req_i` while `load_done_o` is low, and is 0 once `load_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM (reads high when undriven) |
| wr_valid_o | output | 1 | A configuration write is offered |
| wr_ready_i | input | 1 | The consumer accepts the offered write |
| wr_zone_o | output | 1 | 0 = unit preload, 1 = header byte |
| wr_offset_o | output | 7 | Register byte offset |
| wr_data_o | output | 8 | Register value |
| load_done_o | output | 1 | Loading has finished |
| cfg_req_i | input | 1 | Host configuration access request |
| cfg_retry_o | output | 1 | The request must be retried later |

## Verification
Two events can fall in the same cycle. A host configuration request can be present in the very cycle where the final write is accepted and `load_done_o` is about to rise. It can also arrive while a write is being held by back-pressure. To provoke both, the bench keeps requests asserted on three cycles out of four and, in some runs, stalls the ready input in a repeating pattern. A reference built from the EEPROM image predicts the write queue. On every clock, the retry output is compared with the request and the done flag, and the moment done rises is checked against an empty expected queue. Any write seen after done, or any change of payload during a stall, counts as a failure.

// File: rtl/eeprom_cfg_loader_pkg.sv
package eeprom_cfg_loader_pkg;

  typedef enum logic [1:0] {L_IDLE, L_LO, L_HI, L_END} link_st_t;

  typedef enum logic [2:0] {F_DETECT, F_DWAIT, F_READ, F_RWAIT, F_EMIT, F_DONE} fsm_st_t;

  typedef struct packed {
    logic       more;
    logic [6:0] off;
    logic [7:0] val;
  } rec_t;

  localparam int HDR_LIST_N = 5;
  localparam logic [6:0] HDR_LIST [HDR_LIST_N] = '{7'h2E, 7'h2F, 7'h3D, 7'h42, 7'h43};

endpackage

// File: rtl/eeprom_cfg_hdr_filter.sv
module eeprom_cfg_hdr_filter
  import eeprom_cfg_loader_pkg::*;
(
  input  logic [6:0] off_i,
  output logic       ok_o
);
  logic [HDR_LIST_N-1:0] hit;

  for (genvar g = 0; g < HDR_LIST_N; g++) begin : g_cmp
    assign hit[g] = (off_i == HDR_LIST[g]);
  end

  assign ok_o = |hit;
endmodule

// File: rtl/eeprom_cfg_wire_link.sv
module eeprom_cfg_wire_link
  import eeprom_cfg_loader_pkg::*;
#(
  parameter int HALF   = 2,
  parameter int MIN_AW = 6,
  parameter int MAX_AW = 8,
  parameter int WORD_W = 16,
  localparam int AWW   = $clog2(MAX_AW + 1)
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              detect_i,
  input  logic [AWW-1:0]    aw_i,
  input  logic [MAX_AW-1:0] addr_i,
  output logic              done_o,
  output logic              miss_o,
  output logic [AWW-1:0]    aw_o,
  output logic [WORD_W-1:0] word_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  localparam int TW = $clog2(HALF + 1);
  localparam int CW = $clog2(MAX_AW + WORD_W + 4);

  link_st_t          st;
  logic [TW-1:0]     tim;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     nbits;
  logic              in_data;
  logic              det_q;
  logic [AWW-1:0]    awq;
  logic [MAX_AW-1:0] addr_q;

  // bit count of address sent, valid once the command bits are out
  assign nbits = cnt - CW'(2);

  function automatic logic cmd_bit(input int p, input int aw, input logic [MAX_AW-1:0] a);
    int idx;
    if (p < 2) return 1'b1;
    if (p == 2) return 1'b0;
    idx = aw - 1 - (p - 3);
    if (idx >= 0 && idx < MAX_AW) return a[idx];
    return 1'b0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= L_IDLE; tim <= '0; cnt <= '0; in_data <= 1'b0; det_q <= 1'b0;
      awq <= '0; addr_q <= '0; done_o <= 1'b0; miss_o <= 1'b0; aw_o <= '0;
      word_o <= '0; ee_cs_o <= 1'b0; ee_sk_o <= 1'b0; ee_di_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        L_IDLE: if (go_i) begin
          ee_cs_o <= 1'b1; ee_sk_o <= 1'b0; ee_di_o <= 1'b1;
          cnt <= '0; in_data <= 1'b0; det_q <= detect_i; miss_o <= 1'b0;
          awq <= detect_i ? AWW'(MAX_AW) : aw_i;
          addr_q <= detect_i ? '0 : addr_i;
          tim <= TW'(HALF - 1); st <= L_LO;
        end
        L_LO: begin
          if (tim == '0) begin
            ee_sk_o <= 1'b1; tim <= TW'(HALF - 1); st <= L_HI;
          end else tim <= tim - 1'b1;
        end
        L_HI: begin
          if (tim != '0) tim <= tim - 1'b1;
          else begin
            ee_sk_o <= 1'b0; tim <= TW'(HALF - 1); st <= L_LO;
            if (in_data) begin
              word_o <= {word_o[WORD_W-2:0], ee_do_i};
              ee_di_o <= 1'b0;
              cnt <= cnt + 1'b1;
              if (cnt == CW'(WORD_W - 1)) st <= L_END;
            end else if (cnt >= CW'(3) && det_q && !ee_do_i && nbits >= CW'(MIN_AW)) begin
              aw_o <= AWW'(nbits); in_data <= 1'b1; cnt <= '0; ee_di_o <= 1'b0;
            end else if (cnt >= CW'(3) && nbits == CW'(awq)) begin
              if (det_q) begin
                miss_o <= 1'b1; st <= L_END;
              end else begin
                in_data <= 1'b1; cnt <= '0;
              end
              ee_di_o <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
              ee_di_o <= cmd_bit(int'(cnt) + 1, int'(awq), addr_q);
            end
          end
        end
        L_END: begin
          ee_cs_o <= 1'b0; ee_sk_o <= 1'b0; ee_di_o <= 1'b0;
          if (tim == '0) begin
            done_o <= 1'b1; st <= L_IDLE;
          end else tim <= tim - 1'b1;
        end
        default: st <= L_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eeprom_cfg_loader_pkg::*;
#(
  parameter int HALF   = 2,
  parameter int MIN_AW = 6,
  parameter int MAX_AW = 8,
  localparam int AWW   = $clog2(MAX_AW + 1),
  localparam int WORD_W = 16
)(
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       ee_cs_o,
  output logic       ee_sk_o,
  output logic       ee_di_o,
  input  logic       ee_do_i,
  output logic       wr_valid_o,
  input  logic       wr_ready_i,
  output logic       wr_zone_o,
  output logic [6:0] wr_offset_o,
  output logic [7:0] wr_data_o,
  output logic       load_done_o,
  input  logic       cfg_req_i,
  output logic       cfg_retry_o
);
  fsm_st_t           st;
  logic              go_q, det_q, done_q, valid_q;
  logic [AWW-1:0]    aw_q;
  logic [MAX_AW:0]   addr_q, addr_nx, mem_words;
  logic              zone_q, hdr_next_q;
  rec_t              rec_q, link_rec;
  logic              link_done, link_miss, hdr_ok;
  logic [AWW-1:0]    link_aw;
  logic [WORD_W-1:0] link_word;
  logic              more_sel, end_mem, adv_read, adv_switch;

  eeprom_cfg_wire_link #(.HALF(HALF), .MIN_AW(MIN_AW), .MAX_AW(MAX_AW), .WORD_W(WORD_W)) u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_q), .detect_i(det_q), .aw_i(aw_q),
    .addr_i(addr_q[MAX_AW-1:0]), .done_o(link_done), .miss_o(link_miss), .aw_o(link_aw),
    .word_o(link_word), .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_di_o(ee_di_o),
    .ee_do_i(ee_do_i)
  );

  assign link_rec = rec_t'(link_word);

  eeprom_cfg_hdr_filter u_filt (.off_i(link_rec.off), .ok_o(hdr_ok));

  always_comb begin
    more_sel   = (st == F_EMIT) ? rec_q.more : link_rec.more;
    addr_nx    = addr_q + 1'b1;
    mem_words  = (MAX_AW + 1)'(1) << aw_q;
    end_mem    = (addr_nx == mem_words);
    adv_switch = !end_mem && !more_sel && !zone_q && hdr_next_q;
    adv_read   = !end_mem && (more_sel || adv_switch);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= F_DETECT; go_q <= 1'b0; det_q <= 1'b0; done_q <= 1'b0; valid_q <= 1'b0;
      aw_q <= '0; addr_q <= '0; zone_q <= 1'b0; hdr_next_q <= 1'b0; rec_q <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (st)
        F_DETECT: begin go_q <= 1'b1; det_q <= 1'b1; st <= F_DWAIT; end
        F_DWAIT: if (link_done) begin
          aw_q <= link_aw; addr_q <= (MAX_AW + 1)'(1);
          if (link_miss || link_word == '1) st <= F_DONE;
          else if (link_word[0]) begin
            zone_q <= 1'b0; hdr_next_q <= link_word[1]; st <= F_READ;
          end else if (link_word[1]) begin
            zone_q <= 1'b1; hdr_next_q <= 1'b0; st <= F_READ;
          end else st <= F_DONE;
        end
        F_READ: begin go_q <= 1'b1; det_q <= 1'b0; st <= F_RWAIT; end
        F_RWAIT: if (link_done) begin
          rec_q <= link_rec;
          if (!zone_q || hdr_ok) begin
            valid_q <= 1'b1; st <= F_EMIT;
          end else if (adv_read) begin
            addr_q <= addr_nx; st <= F_READ;
            if (adv_switch) begin zone_q <= 1'b1; hdr_next_q <= 1'b0; end
          end else st <= F_DONE;
        end
        F_EMIT: if (wr_ready_i) begin
          valid_q <= 1'b0;
          if (adv_read) begin
            addr_q <= addr_nx; st <= F_READ;
            if (adv_switch) begin zone_q <= 1'b1; hdr_next_q <= 1'b0; end
          end else st <= F_DONE;
        end
        F_DONE: done_q <= 1'b1;
        default: st <= F_DONE;
      endcase
    end
  end

  assign wr_valid_o  = valid_q;
  assign wr_zone_o   = zone_q;
  assign wr_offset_o = rec_q.off;
  assign wr_data_o   = rec_q.val;
  assign load_done_o = done_q;
  assign cfg_retry_o = cfg_req_i & ~done_q;
endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
module eeprom_cfg_loader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ee_cs_o,
  input logic       ee_sk_o,
  input logic       wr_valid_o,
  input logic       wr_ready_i,
  input logic       wr_zone_o,
  input logic [6:0] wr_offset_o,
  input logic [7:0] wr_data_o,
  input logic       load_done_o,
  input logic       cfg_req_i,
  input logic       cfg_retry_o
);
  a_r2_clock_in_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);

  a_r8_header_listed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_zone_o) |-> (wr_offset_o inside {7'h2E, 7'h2F, 7'h3D, 7'h42, 7'h43}));

  a_r10_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_zone_o)
                                     && $stable(wr_offset_o) && $stable(wr_data_o)));

  a_r11_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |=> load_done_o);

  a_r11_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |-> (!wr_valid_o && !ee_cs_o));

  a_r12_retry_only_loading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_retry_o |-> (cfg_req_i && !load_done_o));
endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o),
  .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_zone_o(wr_zone_o),
  .wr_offset_o(wr_offset_o), .wr_data_o(wr_data_o), .load_done_o(load_done_o),
  .cfg_req_i(cfg_req_i), .cfg_retry_o(cfg_retry_o)
);

// File: tb/eeprom_cfg_loader_tb_top.sv
`timescale 1ns/100ps
module eeprom_cfg_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ee_cs, ee_sk, ee_di;
  logic ee_do = 1'b1;
  logic wr_valid, wr_zone, load_done, cfg_retry;
  logic wr_ready = 1'b0;
  logic cfg_req = 1'b0;
  logic [6:0] wr_offset;
  logic [7:0] wr_data;

  eeprom_cfg_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di),
    .ee_do_i(ee_do), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_zone_o(wr_zone),
    .wr_offset_o(wr_offset), .wr_data_o(wr_data), .load_done_o(load_done),
    .cfg_req_i(cfg_req), .cfg_retry_o(cfg_retry)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural serial EEPROM
  bit   ee_present = 1'b0;
  int   ee_aw = 6;
  logic [15:0] mem [256];
  int   bcnt = 0, eaddr = 0, mj = 0;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      bcnt = 0; eaddr = 0; ee_do = 1'b1;
    end else begin
      if (bcnt < 3) chk(ee_di == (bcnt < 2), "R2", "command bit", int'(ee_di), int'(bcnt < 2));
      if (ee_present) begin
        if (bcnt < 3 + ee_aw) begin
          if (bcnt >= 3) eaddr = (eaddr << 1) | int'(ee_di);
          bcnt++;
          if (bcnt == 3 + ee_aw) ee_do = 1'b0;
        end else begin
          mj = bcnt - 3 - ee_aw;
          ee_do = (mj < 16) ? mem[eaddr][15-mj] : 1'b1;
          bcnt++;
        end
      end else bcnt++;
    end
  end

  // reference: expected write stream packed as {zone, offset, value}
  int exp_q[$];

  function automatic bit listed(input logic [6:0] o);
    return o == 7'h2E || o == 7'h2F || o == 7'h3D || o == 7'h42 || o == 7'h43;
  endfunction

  task automatic build_expected();
    logic [15:0] w0, r;
    int z, a;
    bit hdr_after;
    exp_q.delete();
    if (!ee_present) return;
    w0 = mem[0];
    if (w0 == 16'hFFFF) return;
    if (!w0[0] && !w0[1]) return;
    z = w0[0] ? 0 : 1;
    hdr_after = w0[0] && w0[1];
    a = 1;
    while (a < (1 << ee_aw)) begin
      r = mem[a];
      if (z == 0 || listed(r[14:8])) exp_q.push_back((z << 15) | (int'(r[14:8]) << 8) | int'(r[7:0]));
      a++;
      if (!r[15]) begin
        if (z == 0 && hdr_after) begin z = 1; hdr_after = 1'b0; end
        else break;
      end
    end
  endtask

  // per-clock comparison
  bit mon_en = 1'b0, bp = 1'b0;
  int cyc = 0, seen = 0;
  bit stall_prev = 1'b0, done_prev = 1'b0;
  int pay_prev = 0;
  string done_tag = "R7";

  always @(negedge clk) begin
    int pay;
    cyc++;
    if (mon_en) begin
      cfg_req  = (cyc % 4) != 3;
      wr_ready = bp ? (((cyc / 2) % 3) != 0) : 1'b1;
    end else begin
      cfg_req = 1'b0; wr_ready = 1'b0;
    end
    #1;
    if (mon_en) begin
      pay = (int'(wr_zone) << 15) | (int'(wr_offset) << 8) | int'(wr_data);
      chk(cfg_retry == (cfg_req && !load_done), "R12", "retry vs request", int'(cfg_retry),
          int'(cfg_req && !load_done));
      if (done_prev) chk(load_done, "R11", "done stays high", int'(load_done), 1);
      if (stall_prev) chk(wr_valid && pay == pay_prev, "R10", "stalled payload", pay, pay_prev);
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected write", pay, 0);
        else begin
          chk(pay == exp_q[0], wr_zone ? "R8" : "R7", "write payload", pay, exp_q[0]);
          void'(exp_q.pop_front());
        end
        seen++;
      end
      if (load_done && !done_prev)
        chk(exp_q.size() == 0, done_tag, "pending writes at done", exp_q.size(), 0);
      stall_prev = wr_valid && !wr_ready;
      pay_prev   = pay;
      done_prev  = load_done;
    end
  end

  task automatic run(input string tag, input bit back_pressure, input int exp_writes);
    int n;
    mon_en = 1'b0; bp = back_pressure; done_tag = tag;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!ee_cs && !wr_valid && !load_done, "R1", "outputs in reset",
        {ee_cs, wr_valid, load_done}, 0);
    build_expected();
    seen = 0; stall_prev = 1'b0; done_prev = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!ee_cs && !wr_valid && !load_done, "R1", "outputs after reset",
        {ee_cs, wr_valid, load_done}, 0);
    mon_en = 1'b1;
    n = 0;
    while (!load_done && n < 30000) begin @(negedge clk); n++; end
    if (!load_done) chk(1'b0, tag, "watchdog: load never finished", 0, 1);
    repeat (6) @(negedge clk);
    #2;
    chk(seen == exp_writes, tag, "write count", seen, exp_writes);
    chk(!ee_cs && !wr_valid, "R11", "quiet after done", {ee_cs, wr_valid}, 0);
  endtask

  initial begin
    // R3: nothing answers
    ee_present = 1'b0; ee_aw = 6;
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    run("R3", 1'b0, 0);

    // R4: blank device
    ee_present = 1'b1; ee_aw = 6;
    run("R4", 1'b0, 0);

    // R5 R6 R7 R8: both zones, 6-bit device
    mem[0] = 16'h0003;
    mem[1] = 16'h8183; mem[2] = 16'h125A;
    mem[3] = 16'hAE34; mem[4] = 16'h90FF; mem[5] = 16'hBD02; mem[6] = 16'h43C8;
    run("R8", 1'b0, 5);

    // R3 R10: 8-bit device, header zone only, stalled consumer
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    ee_aw = 8;
    mem[0] = 16'h0002;
    mem[1] = 16'hAF11; mem[2] = 16'hC2AA; mem[3] = 16'hBE00; mem[4] = 16'h4355;
    run("R3", 1'b1, 3);

    // R9: continue bit set in every word
    ee_aw = 6;
    mem[0] = 16'h0001;
    for (int i = 1; i < 64; i++) mem[i] = 16'h8000 | 16'(i << 8) | 16'((i ^ 8'hA5) & 8'hFF);
    run("R9", 1'b1, 63);

    // R5: no zone flags
    mem[0] = 16'h0000;
    run("R5", 1'b0, 0);

    mon_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule